// File: doc/BRIEF.md
# Addressed Serial Control Register Bank

This block is a write-only, three-wire serial slave that holds the control settings of a camera analog front-end. A host drives a serial clock, a serial data line and an active-low enable. Each transfer carries a 3-bit address followed by a 10-bit data word. When the enable line returns high, the word is placed in one of five holding registers. Each register drives a parallel control bus: an 8-bit auxiliary output level, two 4-bit bandwidth codes, a 9-bit gain code, six mode flags and a 10-bit clamp reference.

The three serial inputs are asynchronous to the system clock. Each passes through a synchroniser before any edge detection. A transfer commits only if the enable line was low for exactly thirteen serial clock rising edges. Shorter or longer transfers are dropped. Addresses that select no register are ignored. Bits that a register does not use are discarded. A gain code above the usable range is limited on the bus. Each committed write raises a one-cycle strobe for the register that changed.

Top module: `serial_ctrl_bank`

## Requirements
- R1: After reset, every control bus and every strobe bit is zero.
- R2: A transfer is the address A2..A0 followed by the data D9..D0, each field most significant bit first. Bits are sampled on rising edges of the serial clock while the enable line is low.
- R3: A register is updated only when the enable line rises after exactly 13 serial clock rising edges in that transfer. Transfers with fewer or more edges leave every bus and strobe unchanged.
- R4: Address 0 loads `out_level` from D7..D0. D9 and D8 are ignored.
- R5: Address 1 loads `bw_samp` from D3..D0 and `bw_gain` from D7..D4. D9 and D8 are ignored.
- R6: Address 2 loads `gain_code` from D8..D0. A value above 319 appears as 319 on the bus.
- R7: Address 3 loads `mode_flags` from D5..D0, keeping each data bit at the same position. Bit 0 puts the sampling and gain stages in standby. Bit 1 puts the auxiliary converter in standby. Bit 2 puts the fixed-gain amplifier in standby. Bit 3 selects falling-edge sample pulses. Bit 4 selects active-high clamp pulses. Bit 5 at 0 selects a falling-edge converter clock. D9..D6 are ignored.
- R8: Address 4 loads `clamp_ref` from D9..D0.
- R9: Addresses 5, 6 and 7 change no bus and raise no strobe.
- R10: `upd_strobe[n]` pulses high for exactly one system clock when the register at address n is written. At most one strobe bit is high at a time.
- R11: Serial clock edges while the enable line is high are not counted toward the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en_n | input | 1 | Active-low transfer enable, asynchronous |
| out_level | output | 8 | Auxiliary output level code |
| bw_samp | output | 4 | Sampling stage bandwidth code |
| bw_gain | output | 4 | Gain stage bandwidth code |
| gain_code | output | 9 | Gain code, limited to 319 |
| mode_flags | output | 6 | Standby and edge polarity flags |
| clamp_ref | output | 10 | Clamp reference level |
| upd_strobe | output | 5 | One-cycle write strobe per register, indexed by address |

## Verification
The bench uses the default parameters: a two-stage synchroniser and a gain limit of 319. Because the 9-bit gain field can hold codes up to 511, random gain data regularly lands above the limit and exercises the clamp. The serial clock runs at one eighth of the system clock, so every serial edge survives synchronisation. This lets the bench drive transfers of 12, 13 and 14 edges, as well as clock edges with the enable line high. Random addresses cover all eight codes, so the three unused addresses are hit alongside the five registers.

// File: rtl/scb_pkg.sv
package scb_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 10;
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int NUM_REGS  = 5;

  localparam int LEVEL_W = 8;
  localparam int BW_W    = 4;
  localparam int GAIN_W  = 9;
  localparam int MODE_W  = 6;
  localparam int CLAMP_W = 10;

  typedef enum logic [ADDR_W-1:0] {
    RA_LEVEL = 3'd0,
    RA_BW    = 3'd1,
    RA_GAIN  = 3'd2,
    RA_MODE  = 3'd3,
    RA_CLAMP = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/scb_rst_sync.sv
module scb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/scb_sync.sv
module scb_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
    end else begin
      stage_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/scb_shifter.sv
module scb_shifter
  import scb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sen_n_s,
  output logic              frame_ok,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_data
);
  localparam int CNT_MAX = FRAME_LEN + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic                 sclk_d, sen_d;
  logic [FRAME_LEN-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]     cnt_q, cnt_n;
  logic                 sclk_rise, sen_fall, sen_rise;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sen_fall  = ~sen_n_s & sen_d;
  assign sen_rise  = sen_n_s & ~sen_d;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (sen_fall) begin
      sh_n  = '0;
      cnt_n = '0;
    end else if (!sen_n_s && sclk_rise) begin
      sh_n = {sh_q[FRAME_LEN-2:0], sdat_s};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      sen_d  <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
    end else begin
      sclk_d <= sclk_s;
      sen_d  <= sen_n_s;
      sh_q   <= sh_n;
      cnt_q  <= cnt_n;
    end
  end

  assign frame_ok = sen_rise && (cnt_q == CNT_W'(FRAME_LEN));
  assign f_addr   = sh_q[FRAME_LEN-1 -: ADDR_W];
  assign f_data   = sh_q[DATA_W-1:0];

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX)); // R3
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sen_fall |=> (cnt_q == '0)); // R11
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sen_n_s && sen_d) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/scb_reg_bank.sv
module scb_reg_bank
  import scb_pkg::*;
#(
  parameter int GAIN_MAX = 319
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_ok,
  input  logic [ADDR_W-1:0]  f_addr,
  input  logic [DATA_W-1:0]  f_data,
  output logic [LEVEL_W-1:0] out_level,
  output logic [BW_W-1:0]    bw_samp,
  output logic [BW_W-1:0]    bw_gain,
  output logic [GAIN_W-1:0]  gain_code,
  output logic [MODE_W-1:0]  mode_flags,
  output logic [CLAMP_W-1:0] clamp_ref,
  output logic [NUM_REGS-1:0] upd_strobe
);
  localparam logic [GAIN_W-1:0] GAIN_LIM = GAIN_W'(GAIN_MAX);

  logic [NUM_REGS-1:0] we;
  logic [LEVEL_W-1:0]  level_q, level_n;
  logic [BW_W-1:0]     bws_q, bws_n, bwg_q, bwg_n;
  logic [GAIN_W-1:0]   gain_q, gain_n, gain_raw;
  logic [MODE_W-1:0]   mode_q, mode_n;
  logic [CLAMP_W-1:0]  clamp_q, clamp_n;
  logic [NUM_REGS-1:0] strb_q;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : g_dec
      assign we[gi] = frame_ok && (f_addr == ADDR_W'(gi));
    end
  endgenerate

  assign gain_raw = f_data[GAIN_W-1:0];

  always_comb begin
    level_n = level_q;
    bws_n   = bws_q;
    bwg_n   = bwg_q;
    gain_n  = gain_q;
    mode_n  = mode_q;
    clamp_n = clamp_q;
    if (we[RA_LEVEL]) level_n = f_data[LEVEL_W-1:0];
    if (we[RA_BW]) begin
      bws_n = f_data[BW_W-1:0];
      bwg_n = f_data[2*BW_W-1:BW_W];
    end
    if (we[RA_GAIN])  gain_n  = (gain_raw > GAIN_LIM) ? GAIN_LIM : gain_raw;
    if (we[RA_MODE])  mode_n  = f_data[MODE_W-1:0];
    if (we[RA_CLAMP]) clamp_n = f_data[CLAMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      bws_q   <= '0;
      bwg_q   <= '0;
      gain_q  <= '0;
      mode_q  <= '0;
      clamp_q <= '0;
      strb_q  <= '0;
    end else begin
      level_q <= level_n;
      bws_q   <= bws_n;
      bwg_q   <= bwg_n;
      gain_q  <= gain_n;
      mode_q  <= mode_n;
      clamp_q <= clamp_n;
      strb_q  <= we;
    end
  end

  assign out_level  = level_q;
  assign bw_samp    = bws_q;
  assign bw_gain    = bwg_q;
  assign gain_code  = gain_q;
  assign mode_flags = mode_q;
  assign clamp_ref  = clamp_q;
  assign upd_strobe = strb_q;

  AST_GAIN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GAIN_LIM); // R6
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb_q)); // R10
  AST_BAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && f_addr >= ADDR_W'(NUM_REGS)) |=> (strb_q == '0)); // R9
  AST_NO_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> ($stable(clamp_q) && $stable(gain_q) && strb_q == '0)); // R3
  AST_LEVEL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> strb_q[RA_LEVEL]); // R4
endmodule

// File: rtl/serial_ctrl_bank.sv
module serial_ctrl_bank
  import scb_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GAIN_MAX    = 319
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_clk,
  input  logic         ser_dat,
  input  logic         ser_en_n,
  output logic [7:0]   out_level,
  output logic [3:0]   bw_samp,
  output logic [3:0]   bw_gain,
  output logic [8:0]   gain_code,
  output logic [5:0]   mode_flags,
  output logic [9:0]   clamp_ref,
  output logic [4:0]   upd_strobe
);
  logic              rst_sn;
  logic [2:0]        ser_s;
  logic              frame_ok;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;

  scb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  scb_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_sn),
    .d_async({ser_en_n, ser_dat, ser_clk}),
    .q_sync(ser_s)
  );

  scb_shifter u_shift (
    .clk(clk), .rst_n(rst_sn),
    .sclk_s(ser_s[0]), .sdat_s(ser_s[1]), .sen_n_s(ser_s[2]),
    .frame_ok(frame_ok), .f_addr(f_addr), .f_data(f_data)
  );

  scb_reg_bank #(.GAIN_MAX(GAIN_MAX)) u_bank (
    .clk(clk), .rst_n(rst_sn),
    .frame_ok(frame_ok), .f_addr(f_addr), .f_data(f_data),
    .out_level(out_level), .bw_samp(bw_samp), .bw_gain(bw_gain),
    .gain_code(gain_code), .mode_flags(mode_flags), .clamp_ref(clamp_ref),
    .upd_strobe(upd_strobe)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_sn |=> (upd_strobe == '0 && gain_code == '0)); // R1
endmodule

// File: tb/serial_ctrl_bank_tb_top.sv
`timescale 1ns/1ps
module serial_ctrl_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, ser_dat, ser_en_n;
  logic [7:0] out_level;
  logic [3:0] bw_samp, bw_gain;
  logic [8:0] gain_code;
  logic [5:0] mode_flags;
  logic [9:0] clamp_ref;
  logic [4:0] upd_strobe;

  int checks = 0;
  int errors = 0;
  int strb_cnt [5];
  int exp_cnt  [5];
  logic [7:0] e_level;
  logic [3:0] e_bws, e_bwg;
  logic [8:0] e_gain;
  logic [5:0] e_mode;
  logic [9:0] e_clamp;

  always #5 clk = ~clk;

  serial_ctrl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_en_n(ser_en_n), .out_level(out_level), .bw_samp(bw_samp),
    .bw_gain(bw_gain), .gain_code(gain_code), .mode_flags(mode_flags),
    .clamp_ref(clamp_ref), .upd_strobe(upd_strobe)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < 5; i++) if (upd_strobe[i]) strb_cnt[i]++;
    end
  end

  function automatic logic [8:0] gain_model(input logic [9:0] d);
    return (d[8:0] > 9'd319) ? 9'd319 : d[8:0];
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_model(input logic [2:0] a, input logic [9:0] d);
    case (a)
      3'd0: begin e_level = d[7:0]; exp_cnt[0]++; end
      3'd1: begin e_bws = d[3:0]; e_bwg = d[7:4]; exp_cnt[1]++; end
      3'd2: begin e_gain = gain_model(d); exp_cnt[2]++; end
      3'd3: begin e_mode = d[5:0]; exp_cnt[3]++; end
      3'd4: begin e_clamp = d; exp_cnt[4]++; end
      default: ;
    endcase
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [2:0] a, input logic [9:0] d, input int nbits);
    logic [12:0] w;
    w = {a, d};
    ser_en_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 13) ? w[12-i] : 1'b0;
      wait_clk(4);
      ser_clk = 1'b1;
      wait_clk(4);
      ser_clk = 1'b0;
    end
    wait_clk(4);
    ser_en_n = 1'b1;
    if (nbits == 13) apply_model(a, d);
    wait_clk(10);
  endtask

  task automatic check_all(input string tag);
    chk(out_level,  e_level, {tag, " R4 out_level"});
    chk(bw_samp,    e_bws,   {tag, " R5 bw_samp"});
    chk(bw_gain,    e_bwg,   {tag, " R5 bw_gain"});
    chk(gain_code,  e_gain,  {tag, " R6 gain_code"});
    chk(mode_flags, e_mode,  {tag, " R7 mode_flags"});
    chk(clamp_ref,  e_clamp, {tag, " R8 clamp_ref"});
    for (int i = 0; i < 5; i++)
      chk(strb_cnt[i], exp_cnt[i], {tag, " R10 strobe count"});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] ra;
    logic [9:0] rd;
    int rl;
    void'($urandom(32'd2718));
    for (int i = 0; i < 5; i++) begin strb_cnt[i] = 0; exp_cnt[i] = 0; end
    e_level = '0; e_bws = '0; e_bwg = '0; e_gain = '0; e_mode = '0; e_clamp = '0;
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_en_n = 1'b1;
    wait_clk(5);
    check_all("R1 reset");
    chk(upd_strobe, 5'd0, "R1 strobe at reset");
    rst_n = 1'b1;
    wait_clk(5);

    // R2 R4: directed write, D9/D8 set but ignored
    send_frame(3'd0, 10'h3A5, 13);  check_all("R2 level");
    send_frame(3'd1, 10'h3C7, 13);  check_all("R5 bw");
    send_frame(3'd2, 10'd319, 13);  check_all("R6 gain at limit");
    send_frame(3'd2, 10'd320, 13);  check_all("R6 gain above limit");
    send_frame(3'd2, 10'h1FF, 13);  check_all("R6 gain max raw");
    send_frame(3'd3, 10'h3EA, 13);  check_all("R7 mode");
    send_frame(3'd4, 10'h2B9, 13);  check_all("R8 clamp");
    // R9: unused addresses
    send_frame(3'd5, 10'h155, 13);  check_all("R9 addr5");
    send_frame(3'd7, 10'h2AA, 13);  check_all("R9 addr7");
    // R3: short and long transfers
    send_frame(3'd4, 10'h011, 12);  check_all("R3 short");
    send_frame(3'd4, 10'h011, 14);  check_all("R3 long");
    // R11: clock edges with enable high, then a good frame
    for (int k = 0; k < 5; k++) begin
      ser_clk = 1'b1; wait_clk(4); ser_clk = 1'b0; wait_clk(4);
    end
    send_frame(3'd0, 10'h04C, 13);  check_all("R11 idle clocks");

    for (int n = 0; n < 50; n++) begin
      ra = 3'($urandom);
      rd = 10'($urandom);
      rl = (($urandom % 6) == 0) ? 12 + 2 * int'($urandom % 2) : 13;
      send_frame(ra, rd, rl);
      check_all("R2 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule